// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a three-wire link to a serial successive-approximation converter. A one-cycle `start` request in the system clock domain opens a frame: the block drives `cs_n` low, which makes the converter sample its input. It then produces sixteen serial clock periods from a parameterised divider of the system clock. On each rising `sclk` edge it takes one bit from `sdata_in`, most significant first. When the last period ends it raises `cs_n`, extracts an 8-bit field from the 16 received bits, and emits it with a one-cycle `valid` strobe.

Two converter timing rules are built into the sequencing. First, the converter returns to tracking on the 13th rising edge, so the high phase that follows that edge is stretched to the acquisition time given in system cycles. Second, `cs_n` is held high for a programmed quiet time before any new frame may begin. A request that arrives while a frame or the quiet window is still running is remembered and starts the next frame as soon as the window closes. `busy` covers the whole span from request to the end of the quiet window.

Top module: `adc_frame_reader`

## Requirements
- R1: A synchronous reset (`rst` high) sets `cs_n` high, `sclk` high, `valid` low and `busy` low on the next clock edge. It aborts a frame in progress and drops any held request, so no frame follows the reset without a new `start`.
- R2: Every frame has exactly 16 rising and 16 falling `sclk` edges while `cs_n` is low.
- R3: `sclk` is high whenever `cs_n` is high. The first falling `sclk` edge comes at least HALF_DIV (default 4) system cycles after `cs_n` falls.
- R4: The high phase between the 13th rising edge and the next falling edge lasts at least ACQ_CYC system cycles (default 44, i.e. 350 ns at 125 MHz rounded up) and never less than HALF_DIV.
- R5: Every other `sclk` low and high phase inside a frame lasts exactly HALF_DIV system cycles, including the final high phase after the 16th rising edge.
- R6: `sdata_in` is sampled at each rising `sclk` edge, MSB first. The first received bit is frame bit 15 and the last is bit 0. `result` equals frame bits 12 down to 5, which are the eight bits after the three leading bits (LEAD_ZEROS = 3).
- R7: `valid` is a single-cycle pulse in the first cycle that `cs_n` is high after a frame, once per frame. `result` holds its value until the next frame completes.
- R8: Between the rising and the next falling edge of `cs_n`, `cs_n` stays high for at least QUIET_CYC system cycles (default 10).
- R9: A `start` that arrives while `busy` is high is held. It launches the next frame no later than one cycle after the quiet window expires, with no further `start`.
- R10: `busy` is high from the cycle after an accepted `start` through the end of the quiet window. It stays high for exactly QUIET_CYC cycles, counting the `valid` cycle, and then goes low if no request is held.
- R11: While `cs_n` is high, `sdata_in` has no effect: toggling it neither changes `result` nor produces `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle frame request |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles high |
| result | output | 8 | Extracted conversion result |
| valid | output | 1 | One-cycle strobe marking a new result |
| busy | output | 1 | Frame, quiet window or held request in progress |

## Verification
The bench models the converter and drives frame words whose leading and trailing bits are non-zero, so that a field taken one position off, or a sample taken on the wrong edge, gives a wrong `result`. It measures every `sclk` phase in system cycles. This catches a divider that is one cycle short, a 17th falling edge, and a missing stretch after the 13th rising edge (which would show up as a 4-cycle phase where 44 are required). Requests are issued both during a frame and inside the quiet window. A held request that is lost would show up as a missing second frame, and a quiet window that is too short would show up as a `cs_n` gap below QUIET_CYC. A reset in mid-frame with a held request checks that nothing restarts on its own afterwards.

// File: rtl/adc_rdr_pkg.sv
package adc_rdr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_LOW,
      ST_HIGH,
      ST_QUIET
   } rdr_state_t;

   function automatic int max_i(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_rdr_phase_len.sv
// Picks the reload value for the sclk high phase that follows a rising edge.
module adc_rdr_phase_len #(
   parameter int HALF_DIV   = 4,
   parameter int ACQ_CYC    = 44,
   parameter int TRACK_EDGE = 13,
   parameter int EDGE_W     = 5,
   parameter int CNT_W      = 6
) (
   input  logic [EDGE_W-1:0] rise_nxt,
   output logic [CNT_W-1:0]  high_len_m1
);

   localparam logic [CNT_W-1:0]  HALF_M1 = CNT_W'(HALF_DIV - 1);
   localparam logic [CNT_W-1:0]  ACQ_M1  = CNT_W'(ACQ_CYC - 1);
   localparam logic [EDGE_W-1:0] TRK_IDX = EDGE_W'(TRACK_EDGE);

   generate
      if (ACQ_CYC > HALF_DIV) begin : g_stretch
         // acquisition window is longer than a normal half period
         assign high_len_m1 = (rise_nxt == TRK_IDX) ? ACQ_M1 : HALF_M1;
      end else begin : g_plain
         // a normal half period already covers the acquisition window
         logic unused_rise;
         assign unused_rise = ^rise_nxt;
         assign high_len_m1 = HALF_M1;
      end
   endgenerate

endmodule

// File: rtl/adc_rdr_seq.sv
// Frame sequencer: chip select, serial clock, phase timers, quiet window.
module adc_rdr_seq
   import adc_rdr_pkg::*;
#(
   parameter int FRAME_BITS = 16,
   parameter int HALF_DIV   = 4,
   parameter int ACQ_CYC    = 44,
   parameter int QUIET_CYC  = 10,
   parameter int TRACK_EDGE = 13
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic cs_n,
   output logic sclk,
   output logic sample_en,
   output logic end_en,
   output logic busy
);

   localparam int EDGE_W  = $clog2(FRAME_BITS + 1);
   localparam int CNT_MAX = max_i(max_i(HALF_DIV, ACQ_CYC), QUIET_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0]  HALF_M1   = CNT_W'(HALF_DIV - 1);
   localparam logic [CNT_W-1:0]  QUIET_M1  = CNT_W'(QUIET_CYC - 1);
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(FRAME_BITS);
   localparam logic [EDGE_W-1:0] EDGE_ONE  = EDGE_W'(1);

   rdr_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [EDGE_W-1:0] rise_q;
   logic [EDGE_W-1:0] rise_nxt;
   logic [CNT_W-1:0]  high_len_m1;
   logic              pend_q;
   logic              cs_n_q;
   logic              sclk_q;
   logic              cnt_zero;

   assign cnt_zero = (cnt_q == '0);
   assign rise_nxt = rise_q + EDGE_ONE;

   adc_rdr_phase_len #(
      .HALF_DIV  (HALF_DIV),
      .ACQ_CYC   (ACQ_CYC),
      .TRACK_EDGE(TRACK_EDGE),
      .EDGE_W    (EDGE_W),
      .CNT_W     (CNT_W)
   ) u_phase (
      .rise_nxt   (rise_nxt),
      .high_len_m1(high_len_m1)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         rise_q  <= '0;
         pend_q  <= 1'b0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b1;
      end else begin
         if (start && (state_q != ST_IDLE)) begin
            pend_q <= 1'b1;
         end
         case (state_q)
            ST_IDLE: begin
               if (start || pend_q) begin
                  state_q <= ST_LEAD;
                  cs_n_q  <= 1'b0;
                  cnt_q   <= HALF_M1;
                  rise_q  <= '0;
                  pend_q  <= 1'b0;
               end
            end
            ST_LEAD: begin
               if (cnt_zero) begin
                  state_q <= ST_LOW;
                  sclk_q  <= 1'b0;
                  cnt_q   <= HALF_M1;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            ST_LOW: begin
               if (cnt_zero) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
                  rise_q  <= rise_nxt;
                  cnt_q   <= high_len_m1;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            ST_HIGH: begin
               if (cnt_zero) begin
                  if (rise_q == LAST_EDGE) begin
                     state_q <= ST_QUIET;
                     cs_n_q  <= 1'b1;
                     cnt_q   <= QUIET_M1;
                  end else begin
                     state_q <= ST_LOW;
                     sclk_q  <= 1'b0;
                     cnt_q   <= HALF_M1;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            ST_QUIET: begin
               if (cnt_zero) begin
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - CNT_ONE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sample_en = (state_q == ST_LOW) && cnt_zero;
   assign end_en    = (state_q == ST_HIGH) && cnt_zero && (rise_q == LAST_EDGE);
   assign busy      = (state_q != ST_IDLE) || pend_q;
   assign cs_n      = cs_n_q;
   assign sclk      = sclk_q;

endmodule

// File: rtl/adc_rdr_capture.sv
// Shift register and result field extraction.
module adc_rdr_capture #(
   parameter int FRAME_BITS = 16,
   parameter int RESULT_W   = 8,
   parameter int LEAD_ZEROS = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cs_n,
   input  logic                sample_en,
   input  logic                end_en,
   input  logic                sdata_in,
   output logic [RESULT_W-1:0] result,
   output logic                valid
);

   localparam int TOP_BIT = FRAME_BITS - 1 - LEAD_ZEROS;

   logic [FRAME_BITS-1:0] shift_q;
   logic [RESULT_W-1:0]   result_q;
   logic                  valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q  <= '0;
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         if (sample_en && !cs_n) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], sdata_in};
         end
         if (end_en) begin
            result_q <= shift_q[TOP_BIT -: RESULT_W];
         end
         valid_q <= end_en;
      end
   end

   assign result = result_q;
   assign valid  = valid_q;

endmodule

// File: rtl/adc_frame_reader.sv
// Host-side reader for one serial converter frame.
module adc_frame_reader #(
   parameter int FRAME_BITS = 16,
   parameter int RESULT_W   = 8,
   parameter int LEAD_ZEROS = 3,
   parameter int TRACK_EDGE = 13,
   parameter int HALF_DIV   = 4,
   parameter int ACQ_CYC    = 44,
   parameter int QUIET_CYC  = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic                sdata_in,
   output logic                cs_n,
   output logic                sclk,
   output logic [RESULT_W-1:0] result,
   output logic                valid,
   output logic                busy
);

   generate
      if (HALF_DIV < 1) begin : g_chk_div
         $error("HALF_DIV must be at least 1");
      end
      if (FRAME_BITS < 2) begin : g_chk_frame
         $error("FRAME_BITS must be at least 2");
      end
      if (LEAD_ZEROS + RESULT_W > FRAME_BITS || RESULT_W < 1 || LEAD_ZEROS < 0) begin : g_chk_field
         $error("result field does not fit in the frame");
      end
      if (TRACK_EDGE < 1 || TRACK_EDGE > FRAME_BITS) begin : g_chk_track
         $error("TRACK_EDGE must name a rising edge inside the frame");
      end
      if (ACQ_CYC < 1 || QUIET_CYC < 1) begin : g_chk_time
         $error("ACQ_CYC and QUIET_CYC must be at least 1");
      end
   endgenerate

   logic sample_en;
   logic end_en;

   adc_rdr_seq #(
      .FRAME_BITS(FRAME_BITS),
      .HALF_DIV  (HALF_DIV),
      .ACQ_CYC   (ACQ_CYC),
      .QUIET_CYC (QUIET_CYC),
      .TRACK_EDGE(TRACK_EDGE)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .cs_n     (cs_n),
      .sclk     (sclk),
      .sample_en(sample_en),
      .end_en   (end_en),
      .busy     (busy)
   );

   adc_rdr_capture #(
      .FRAME_BITS(FRAME_BITS),
      .RESULT_W  (RESULT_W),
      .LEAD_ZEROS(LEAD_ZEROS)
   ) u_cap (
      .clk      (clk),
      .rst      (rst),
      .cs_n     (cs_n),
      .sample_en(sample_en),
      .end_en   (end_en),
      .sdata_in (sdata_in),
      .result   (result),
      .valid    (valid)
   );

endmodule

// File: rtl/adc_rdr_checker.sv
// Protocol checker, bound to the top module.
module adc_rdr_checker #(
   parameter int FRAME_BITS = 16,
   parameter int QUIET_CYC  = 10
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic cs_n,
   input logic sclk,
   input logic valid,
   input logic busy
);

   localparam int GAP_W = $clog2(QUIET_CYC + 1);
   localparam int RW    = $clog2(FRAME_BITS + 2);
   localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(QUIET_CYC);
   localparam logic [RW-1:0]    RISE_LIM = RW'(FRAME_BITS);

   logic [GAP_W-1:0] gap_q;
   logic [RW-1:0]    rises_q;
   logic             sclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q   <= GAP_LIM;
         rises_q <= '0;
         sclk_d  <= 1'b1;
      end else begin
         sclk_d <= sclk;
         if (!cs_n) begin
            gap_q <= '0;
         end else if (gap_q < GAP_LIM) begin
            gap_q <= gap_q + GAP_W'(1);
         end
         if (cs_n) begin
            rises_q <= '0;
         end else if (sclk && !sclk_d && (rises_q != '1)) begin
            rises_q <= rises_q + RW'(1);
         end
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (cs_n && sclk && !valid && !busy)); // R1

   AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
      rises_q <= RISE_LIM); // R2

   AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> sclk); // R3

   AST_LEAD_HIGH: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> sclk); // R3

   AST_VALID_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
      valid |-> cs_n); // R7

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid); // R7

   AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> (gap_q >= GAP_LIM)); // R8

   AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
      start |=> busy); // R10

endmodule

bind adc_frame_reader adc_rdr_checker #(
   .FRAME_BITS(FRAME_BITS),
   .QUIET_CYC (QUIET_CYC)
) u_chk (
   .clk  (clk),
   .rst  (rst),
   .start(start),
   .cs_n (cs_n),
   .sclk (sclk),
   .valid(valid),
   .busy (busy)
);

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

   localparam int FRAME_BITS = 16;
   localparam int RESULT_W   = 8;
   localparam int LEAD_ZEROS = 3;
   localparam int HALF_DIV   = 4;
   localparam int ACQ_CYC    = 44;
   localparam int QUIET_CYC  = 10;
   localparam int TOP_BIT    = FRAME_BITS - 1 - LEAD_ZEROS;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic sdata_in;
   logic cs_n;
   logic sclk;
   logic [RESULT_W-1:0] result;
   logic valid;
   logic busy;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   adc_frame_reader dut (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .sdata_in(sdata_in),
      .cs_n    (cs_n),
      .sclk    (sclk),
      .result  (result),
      .valid   (valid),
      .busy    (busy)
   );

   // converter model: bit 15 appears on the first falling sclk edge
   logic [FRAME_BITS-1:0] adc_word = '0;
   logic junk = 1'b1;
   int   bit_idx = FRAME_BITS;

   always @(negedge cs_n or negedge sclk) begin
      if (cs_n === 1'b0 && sclk === 1'b1) bit_idx = FRAME_BITS;
      else if (cs_n === 1'b0) bit_idx = bit_idx - 1;
   end

   assign sdata_in = (cs_n === 1'b0 && bit_idx >= 0 && bit_idx < FRAME_BITS)
                     ? adc_word[bit_idx[3:0]] : junk;

   // port monitor, sampled on the falling system clock edge
   logic prev_cs = 1'b1;
   logic prev_sclk = 1'b1;
   int run_len = 0, rises = 0, falls = 0, lead_cnt = 0, lead_len = 0;
   int hi13 = 0, bad_hi = 0, bad_lo = 0, valid_cnt = 0;
   int cs_high_len = 0, last_gap = 0;

   always @(negedge clk) begin
      if (prev_cs && !cs_n) begin
         rises = 0; falls = 0; bad_hi = 0; bad_lo = 0;
         lead_cnt = 0; valid_cnt = 0; last_gap = cs_high_len;
      end
      if (!prev_cs && cs_n && run_len != HALF_DIV) bad_hi++;
      if (sclk != prev_sclk) begin
         if (!sclk && !cs_n) begin
            falls++;
            if (falls == 1) lead_len = lead_cnt;
            else if (falls - 1 == 13) hi13 = run_len;
            else if (run_len != HALF_DIV) bad_hi++;
         end
         if (sclk && !cs_n) begin
            rises++;
            if (run_len != HALF_DIV) bad_lo++;
         end
         run_len = 1;
      end else begin
         run_len++;
      end
      if (!cs_n && falls == 0) lead_cnt++;
      if (cs_n) cs_high_len++;
      else cs_high_len = 0;
      if (valid) valid_cnt++;
      prev_cs = cs_n;
      prev_sclk = sclk;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_valid(output bit seen, output int busy_lo);
      seen = 1'b0;
      busy_lo = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (!busy) busy_lo++;
         if (valid) begin
            seen = 1'b1;
            break;
         end
      end
   endtask

   task automatic check_frame(input logic [FRAME_BITS-1:0] word, input bit seen);
      check(seen, "R7", "valid seen", seen, 1);
      check(cs_n == 1'b1, "R7", "cs_n high with valid", cs_n, 1);
      check(result == word[TOP_BIT -: RESULT_W], "R6", "result field",
            result, word[TOP_BIT -: RESULT_W]);
      check(rises == FRAME_BITS, "R2", "rising edges", rises, FRAME_BITS);
      check(falls == FRAME_BITS, "R2", "falling edges", falls, FRAME_BITS);
      check(lead_len >= HALF_DIV, "R3", "lead before first fall", lead_len, HALF_DIV);
      check(hi13 >= ACQ_CYC && hi13 >= HALF_DIV, "R4", "high after edge 13", hi13, ACQ_CYC);
      check(bad_hi == 0 && bad_lo == 0, "R5", "off-length phases", bad_hi + bad_lo, 0);
   endtask

   // single frame with busy tracking
   task automatic t_single(input logic [FRAME_BITS-1:0] word);
      bit seen;
      int busy_lo;
      int n;
      adc_word = word;
      pulse_start();
      check(busy == 1'b1, "R10", "busy after start", busy, 1);
      wait_valid(seen, busy_lo);
      check_frame(word, seen);
      check(busy_lo == 0, "R10", "busy gaps in frame", busy_lo, 0);
      n = busy ? 1 : 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (busy) n++;
         else break;
      end
      check(n == QUIET_CYC, "R10", "busy cycles from valid", n, QUIET_CYC);
      check(valid_cnt == 1, "R7", "valid pulses per frame", valid_cnt, 1);
   endtask

   // second request during the frame is held (R9), gap honoured (R8)
   task automatic t_held_in_frame(input logic [FRAME_BITS-1:0] wa,
                                  input logic [FRAME_BITS-1:0] wb);
      bit seen;
      int busy_lo;
      adc_word = wa;
      pulse_start();
      repeat (20) @(negedge clk);
      pulse_start();
      wait_valid(seen, busy_lo);
      check_frame(wa, seen);
      adc_word = wb;
      wait_valid(seen, busy_lo);
      check(seen, "R9", "held request ran", seen, 1);
      check_frame(wb, seen);
      check(last_gap >= QUIET_CYC, "R8", "cs_n quiet gap", last_gap, QUIET_CYC);
      check(last_gap <= QUIET_CYC + 1, "R9", "held launch delay", last_gap, QUIET_CYC + 1);
      repeat (QUIET_CYC + 3) @(negedge clk);
   endtask

   // request inside the quiet window (R8, R9)
   task automatic t_held_in_quiet(input logic [FRAME_BITS-1:0] wa,
                                  input logic [FRAME_BITS-1:0] wb);
      bit seen;
      int busy_lo;
      adc_word = wa;
      pulse_start();
      wait_valid(seen, busy_lo);
      check_frame(wa, seen);
      adc_word = wb;
      @(negedge clk);
      pulse_start();
      wait_valid(seen, busy_lo);
      check_frame(wb, seen);
      check(last_gap >= QUIET_CYC, "R8", "gap with quiet request", last_gap, QUIET_CYC);
      check(last_gap <= QUIET_CYC + 1, "R9", "quiet request delay", last_gap, QUIET_CYC + 1);
      repeat (QUIET_CYC + 3) @(negedge clk);
   endtask

   // data line toggling while deselected (R11)
   task automatic t_ignore_idle();
      logic [RESULT_W-1:0] r0;
      int vhits = 0;
      int cs_lo = 0;
      r0 = result;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         junk = ~junk;
         if (valid) vhits++;
         if (!cs_n) cs_lo++;
      end
      junk = 1'b1;
      check(vhits == 0, "R11", "valid while idle", vhits, 0);
      check(result == r0, "R11", "result while idle", result, r0);
      check(cs_lo == 0, "R11", "cs_n low while idle", cs_lo, 0);
   endtask

   // reset inside a frame with a held request (R1)
   task automatic t_reset_mid();
      int cs_lo = 0;
      adc_word = 16'hFFFF;
      pulse_start();
      repeat (30) @(negedge clk);
      pulse_start();
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b1, "R1", "cs_n/sclk after mid reset",
            {cs_n, sclk}, 3);
      check(valid == 1'b0 && busy == 1'b0, "R1", "valid/busy after mid reset",
            {valid, busy}, 0);
      rst = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (!cs_n) cs_lo++;
      end
      check(cs_lo == 0, "R1", "no frame after reset", cs_lo, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end

   initial begin
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check(cs_n == 1'b1 && sclk == 1'b1, "R1", "cs_n/sclk in reset", {cs_n, sclk}, 3);
      check(valid == 1'b0 && busy == 1'b0, "R1", "valid/busy in reset", {valid, busy}, 0);
      rst = 1'b0;
      repeat (2) @(negedge clk);

      t_single(16'b1111_0110_1001_0111);
      t_single(16'b0000_1111_1110_0000);
      t_single(16'b1110_0000_0001_1111);
      t_ignore_idle();
      t_held_in_frame(16'hA5C3, 16'h5A3C);
      t_held_in_quiet(16'h1FE0, 16'hE01F);
      t_reset_mid();
      t_single(16'b0001_0101_0101_0000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule